// File: doc/BRIEF.md
# I2C Byte Master with Status Codes

This block is a master on an I2C bus that works one byte at a time. Software uses a small register file. It writes a control byte that asks for a START, a STOP or the next byte, and it chooses whether a received byte is acknowledged. It then waits for the completion flag. The flag rises once each bus step has finished. At that moment an 8-bit status code describes the new bus situation, for example "start sent", "address acknowledged" or "byte received and NAKed". Until software writes the control register again, the clock stays low and the bus does not move.

Any control write clears the flag. The same write launches the next step, so a transaction is a chain of control writes, each one followed by a wait for the flag. SCL and SDA are open-drain lines. The block drives each one as a pull-low enable and reads it back through a sampled input. If the block loses arbitration, it reports a status code for it and lets go of both lines.

The register offsets are:
- 0: control (read/write)
- 1: data (read/write)
- 2: status (read only)
- 3: own-address (read/write, stored only)
- 4: clock divider (read/write)
- 5: soft reset (a write of any value)

Top module: `i2c_byte_master`

## Requirements
- R1: After hardware reset, or after any write to offset 5, the following hold: the status reads 0xF8, the flag is clear, both lines are released, the divider reads 4 and the own-address reads 0x00.
- R2: A control write with enable (bit 6) and START (bit 5) behaves as follows. From idle it sends a start condition, raises the flag (control bit 3) and posts 0x08. While the bus is still held after a finished byte, it sends a repeated start without a stop and posts 0x10.
- R3: The first byte after a start is the address byte, and its bit 0 selects read (1) or write (0). It completes with 0x18 for a write address that is ACKed and 0x20 for one that is NAKed. It completes with 0x40 for a read address that is ACKed and 0x48 for one that is NAKed.
- R4: A transmitted data byte goes out MSB first, and SDA changes only while SCL is held low. The byte completes with 0x28 when ACKed and 0x30 when NAKed.
- R5: After a read address has been ACKed, each launch receives one byte into the data register. The answer to that byte follows control bit 2 of the launching write: 1 sends an ACK and posts 0x50, 0 sends a NAK and posts 0x58.
- R6: While the flag is set and no control write arrives, the flag stays set and SCL stays pulled low. Any control write clears the flag, and it reads 0 on the following cycle.
- R7: A control write with enable and STOP (bit 4) while the bus is held sends a stop condition and does not raise the flag. Once SCL and SDA both read high, the block posts 0xF8.
- R8: A control write whose enable bit is 0 starts no bus activity.
- R9: The irq output is high exactly when the flag is set and interrupt enable (control bit 7) is 1.
- R10: Arbitration is lost when SDA reads low while the block is sending a 1 bit. The block then releases both lines, raises the flag and posts 0x38. The next control write with no START returns the status to 0xF8.
- R11: Each SCL high phase lasts 2*(D+1) clock cycles, where D is the divider value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench connects a behavioural target device. That target ACKs or NAKs its address and data on command and returns a fixed byte sequence on reads. A plain write transaction checks the address and data codes for the ACK case against the byte the target captured. A write-then-repeated-start-read transaction separates 0x10 from 0x08 and 0x50 from 0x58, and it shows the data register taking the received bytes. Runs with the target refusing its address, and with it refusing data, separate the NAK codes 0x20, 0x48 and 0x30 from their ACK counterparts. A line forced low from outside triggers the 0x38 path. Measured SCL high times at two divider settings tell apart a correct and an off-by-one quarter period.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int                BAUD_W   = 8,
  parameter logic [BAUD_W-1:0] BAUD_RST = 4,
  parameter logic [7:0]        OWN_RST  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);

  localparam logic [2:0] A_CTL = 3'd0, A_DAT = 3'd1, A_STA = 3'd2,
                         A_OWN = 3'd3, A_DIV = 3'd4, A_RST = 3'd5;
  localparam int B_ACK = 2, B_FLG = 3, B_STP = 4, B_STA = 5, B_EN = 6, B_IE = 7;
  localparam logic [7:0] C_START = 8'h08, C_RSTART = 8'h10,
                         C_AW_ACK = 8'h18, C_AW_NAK = 8'h20,
                         C_DW_ACK = 8'h28, C_DW_NAK = 8'h30, C_ARB = 8'h38,
                         C_AR_ACK = 8'h40, C_AR_NAK = 8'h48,
                         C_DR_ACK = 8'h50, C_DR_NAK = 8'h58, C_IDLE = 8'hF8;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_HOLD, S_STOP} st_t;

  st_t               st_q;
  logic [1:0]        qtr_q;
  logic [3:0]        bitn_q;
  logic [7:0]        sh_q, data_q, stat_q, own_q;
  logic [BAUD_W-1:0] baud_q, cnt_q;
  logic              ctl_ack_q, ctl_en_q, ctl_ie_q, iflg_q;
  logic              is_rx_q, ack_out_q, addr_ph_q, rx_mode_q, rw_q, nak_q, rs_q;
  logic              scl_oe_q, sda_oe_q;

  wire wr_ctl = reg_wr && (reg_addr == A_CTL);
  wire srst   = reg_wr && (reg_addr == A_RST);
  wire busy   = (st_q == S_START) || (st_q == S_BIT) || (st_q == S_STOP);
  wire tick   = busy && (cnt_q == baud_q);

  assign scl_oe = scl_oe_q;
  assign sda_oe = sda_oe_q;
  assign irq    = iflg_q & ctl_ie_q;

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = {ctl_ie_q, ctl_en_q, 2'b00, iflg_q, ctl_ack_q, 2'b00};
      A_DAT:   reg_rdata = data_q;
      A_STA:   reg_rdata = stat_q;
      A_OWN:   reg_rdata = own_q;
      A_DIV:   reg_rdata = 8'(baud_q);
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (srst || !busy || tick)    cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; qtr_q <= '0; bitn_q <= '0; sh_q <= '0; data_q <= '0;
      stat_q <= C_IDLE; own_q <= OWN_RST; baud_q <= BAUD_RST;
      ctl_ack_q <= 1'b0; ctl_en_q <= 1'b0; ctl_ie_q <= 1'b0; iflg_q <= 1'b0;
      is_rx_q <= 1'b0; ack_out_q <= 1'b0; addr_ph_q <= 1'b0; rx_mode_q <= 1'b0;
      rw_q <= 1'b0; nak_q <= 1'b0; rs_q <= 1'b0; scl_oe_q <= 1'b0; sda_oe_q <= 1'b0;
    end else if (srst) begin
      st_q <= S_IDLE; qtr_q <= '0; bitn_q <= '0; sh_q <= '0; data_q <= '0;
      stat_q <= C_IDLE; own_q <= OWN_RST; baud_q <= BAUD_RST;
      ctl_ack_q <= 1'b0; ctl_en_q <= 1'b0; ctl_ie_q <= 1'b0; iflg_q <= 1'b0;
      is_rx_q <= 1'b0; ack_out_q <= 1'b0; addr_ph_q <= 1'b0; rx_mode_q <= 1'b0;
      rw_q <= 1'b0; nak_q <= 1'b0; rs_q <= 1'b0; scl_oe_q <= 1'b0; sda_oe_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_DAT) data_q <= reg_wdata;
      if (reg_wr && reg_addr == A_OWN) own_q  <= reg_wdata;
      if (reg_wr && reg_addr == A_DIV) baud_q <= reg_wdata[BAUD_W-1:0];

      if (wr_ctl) begin
        ctl_ack_q <= reg_wdata[B_ACK];
        ctl_en_q  <= reg_wdata[B_EN];
        ctl_ie_q  <= reg_wdata[B_IE];
        iflg_q    <= 1'b0;
        if (reg_wdata[B_EN]) begin
          if (reg_wdata[B_STP] && st_q == S_HOLD) begin
            st_q  <= S_STOP;
            qtr_q <= '0;
          end else if (reg_wdata[B_STA] && (st_q == S_IDLE || st_q == S_HOLD)) begin
            st_q  <= S_START;
            qtr_q <= '0;
            rs_q  <= (st_q == S_HOLD);
          end else if (st_q == S_HOLD) begin
            st_q      <= S_BIT;
            qtr_q     <= '0;
            bitn_q    <= '0;
            sh_q      <= data_q;
            is_rx_q   <= rx_mode_q && !addr_ph_q;
            ack_out_q <= reg_wdata[B_ACK];
            if (addr_ph_q) rw_q <= data_q[0];
          end else if (st_q == S_IDLE) begin
            stat_q <= C_IDLE;
          end
        end
      end

      if (tick) begin
        case (st_q)
          S_START: begin
            qtr_q <= qtr_q + 1'b1;
            case (qtr_q)
              2'd0: sda_oe_q <= 1'b0;
              2'd1: scl_oe_q <= 1'b0;
              2'd2: sda_oe_q <= 1'b1;
              default: begin
                scl_oe_q  <= 1'b1;
                st_q      <= S_HOLD;
                iflg_q    <= 1'b1;
                stat_q    <= rs_q ? C_RSTART : C_START;
                addr_ph_q <= 1'b1;
                rx_mode_q <= 1'b0;
              end
            endcase
          end
          S_BIT: begin
            case (qtr_q)
              2'd0: begin
                sda_oe_q <= (bitn_q == 4'd8) ? (is_rx_q & ack_out_q) : (!is_rx_q & !sh_q[7]);
                qtr_q    <= 2'd1;
              end
              2'd1: begin
                scl_oe_q <= 1'b0;
                qtr_q    <= 2'd2;
              end
              2'd2: begin
                if (bitn_q == 4'd8) begin
                  nak_q <= sda_i;
                  qtr_q <= 2'd3;
                end else if (!is_rx_q && sh_q[7] && !sda_i) begin
                  st_q      <= S_IDLE;
                  scl_oe_q  <= 1'b0;
                  sda_oe_q  <= 1'b0;
                  iflg_q    <= 1'b1;
                  stat_q    <= C_ARB;
                  addr_ph_q <= 1'b0;
                  rx_mode_q <= 1'b0;
                end else begin
                  sh_q  <= {sh_q[6:0], sda_i};
                  qtr_q <= 2'd3;
                end
              end
              default: begin
                scl_oe_q <= 1'b1;
                qtr_q    <= 2'd0;
                if (bitn_q != 4'd8) begin
                  bitn_q <= bitn_q + 1'b1;
                end else begin
                  st_q   <= S_HOLD;
                  iflg_q <= 1'b1;
                  if (addr_ph_q) begin
                    addr_ph_q <= 1'b0;
                    rx_mode_q <= rw_q && !nak_q;
                    if (rw_q) stat_q <= nak_q ? C_AR_NAK : C_AR_ACK;
                    else      stat_q <= nak_q ? C_AW_NAK : C_AW_ACK;
                  end else if (is_rx_q) begin
                    data_q <= sh_q;
                    stat_q <= ack_out_q ? C_DR_ACK : C_DR_NAK;
                  end else begin
                    stat_q <= nak_q ? C_DW_NAK : C_DW_ACK;
                  end
                end
              end
            endcase
          end
          S_STOP: begin
            case (qtr_q)
              2'd0: begin sda_oe_q <= 1'b1; qtr_q <= 2'd1; end
              2'd1: begin scl_oe_q <= 1'b0; qtr_q <= 2'd2; end
              2'd2: begin sda_oe_q <= 1'b0; qtr_q <= 2'd3; end
              default: begin
                if (scl_i && sda_i) begin
                  st_q   <= S_IDLE;
                  stat_q <= C_IDLE;
                  qtr_q  <= 2'd0;
                end
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg_q && !wr_ctl && !srst) |=> iflg_q);

  p_bus_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg_q && !wr_ctl && !srst) |=> ($stable(scl_oe_q) && $stable(sda_oe_q)));

  p_hold_clock_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HOLD) |-> scl_oe_q);

  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> !scl_oe_q);

  p_code_on_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflg_q) |-> (stat_q != C_IDLE));

  p_stop_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STOP && !srst) |=> (st_q == S_STOP) || (st_q == S_IDLE && !iflg_q && stat_q == C_IDLE));

  p_sda_low_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BIT && $past(st_q) == S_BIT && sda_oe_q != $past(sda_oe_q)) |-> scl_oe_q);

endmodule

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  localparam logic [7:0] EN = 8'h40, STA = 8'h20, STP = 8'h10, ACK = 8'h04, IE = 8'h80;
  localparam logic [6:0] SADR = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic s_oe = 1'b0, ext_pull = 1'b0;
  wire scl_w = ~scl_oe;
  wire sda_w = ~(sda_oe | s_oe | ext_pull);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe));

  always #5 clk = ~clk;

  // behavioural target device
  int s_st = 0, s_bit = 0, s_txi = 0;
  logic [7:0] s_sh = 8'h00, s_last = 8'h00;
  logic [7:0] s_tx [2];
  bit s_rw = 1'b0, s_mack = 1'b0, s_ack_addr = 1'b1, s_ack_data = 1'b1;
  initial begin s_tx[0] = 8'hC5; s_tx[1] = 8'h5A; end

  always @(negedge sda_w) if (scl_w === 1'b1) begin s_st = 1; s_bit = 0; s_oe = 1'b0; end
  always @(posedge sda_w) if (scl_w === 1'b1) begin s_st = 0; s_oe = 1'b0; end
  always @(posedge scl_w) if (s_st != 0) begin
    if (s_bit < 8) begin
      if (s_st != 3) s_sh = {s_sh[6:0], sda_w};
      s_bit++;
    end else begin
      if (s_st == 3) s_mack = !sda_w;
      s_bit = 9;
    end
  end
  always @(negedge scl_w) if (s_st != 0) begin
    if (s_bit == 8 && s_st != 3) begin
      if (s_st == 1) begin
        if (s_sh[7:1] == SADR && s_ack_addr) begin s_oe = 1'b1; s_rw = s_sh[0]; end
        else begin s_st = 0; s_oe = 1'b0; end
      end else begin
        s_last = s_sh; s_oe = s_ack_data;
      end
    end else if (s_bit == 9) begin
      s_oe = 1'b0; s_bit = 0;
      if (s_st == 1) begin s_st = s_rw ? 3 : 2; s_txi = 0; end
      else if (s_st == 3 && !s_mack) s_st = 0;
      else if (s_st == 3) s_txi++;
      if (s_st == 3) s_oe = !s_tx[s_txi][7];
    end else if (s_st == 3 && s_bit >= 1 && s_bit <= 7) s_oe = !s_tx[s_txi][7-s_bit];
    else if (s_st == 3 && s_bit == 8) s_oe = 1'b0;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_flag(input string req);
    logic [7:0] c;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); rd(3'd0, c);
      if (c[3]) return;
    end
    chk({req, " flag timeout"}, 0, 1);
  endtask

  task automatic step(input logic [7:0] ctl, input logic [7:0] code, input string req);
    logic [7:0] s;
    wr(3'd0, ctl); wait_flag(req); rd(3'd2, s); chk(req, s, code);
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] ctl, input logic [7:0] code, input string req);
    wr(3'd1, b); step(ctl, code, req);
  endtask

  task automatic do_stop(input string req);
    logic [7:0] s, c;
    bit seen = 1'b0, idle = 1'b0;
    wr(3'd0, EN | STP);
    for (int i = 0; i < 4000 && !idle; i++) begin
      @(negedge clk); rd(3'd0, c); if (c[3]) seen = 1'b1;
      rd(3'd2, s); if (s == 8'hF8) idle = 1'b1;
    end
    chk({req, " stop status"}, s, 8'hF8);
    chk({req, " no flag on stop"}, int'(seen), 0);
    chk({req, " lines high"}, {scl_w, sda_w}, 2'b11);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(3'd2, v); chk("R1 status", v, 8'hF8);
    rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(3'd4, v); chk("R1 divider", v, 8'd4);
    rd(3'd3, v); chk("R1 own", v, 8'h00);
    chk("R1 lines", {scl_w, sda_w}, 2'b11);
  endtask

  task automatic t_write_path;
    logic [7:0] c;
    s_ack_addr = 1'b1; s_ack_data = 1'b1;
    step(EN | IE | STA, 8'h08, "R2 start");
    chk("R9 irq on flag", irq, 1);
    wr(3'd1, 8'hA0); wr(3'd0, EN | IE);
    rd(3'd0, c); chk("R6 flag cleared", c[3], 0);
    chk("R9 irq low", irq, 0);
    wait_flag("R3");
    rd(3'd2, c); chk("R3 write addr ack", c, 8'h18);
    repeat (60) @(negedge clk);
    rd(3'd0, c); chk("R6 flag held", c[3], 1);
    chk("R6 scl held low", scl_w, 0);
    send(8'h3C, EN | IE, 8'h28, "R4 data ack");
    chk("R4 byte at target", s_last, 8'h3C);
    do_stop("R7");
  endtask

  task automatic t_read_path;
    logic [7:0] d;
    s_ack_addr = 1'b1; s_ack_data = 1'b1;
    step(EN | STA, 8'h08, "R2 start");
    send(8'hA0, EN, 8'h18, "R3 write addr");
    send(8'h10, EN, 8'h28, "R4 offset byte");
    step(EN | STA, 8'h10, "R2 repeated start");
    chk("R9 irq masked", irq, 0);
    send(8'hA1, EN, 8'h40, "R3 read addr ack");
    step(EN | ACK, 8'h50, "R5 rx ack");
    rd(3'd1, d); chk("R5 rx byte 0", d, 8'hC5);
    step(EN, 8'h58, "R5 rx nak");
    rd(3'd1, d); chk("R5 rx byte 1", d, 8'h5A);
    do_stop("R7");
  endtask

  task automatic t_nak_paths;
    s_ack_addr = 1'b0;
    step(EN | STA, 8'h08, "R2 start");
    send(8'hA0, EN, 8'h20, "R3 write addr nak");
    do_stop("R7");
    step(EN | STA, 8'h08, "R2 start");
    send(8'hA1, EN, 8'h48, "R3 read addr nak");
    do_stop("R7");
    s_ack_addr = 1'b1; s_ack_data = 1'b0;
    step(EN | STA, 8'h08, "R2 start");
    send(8'hA0, EN, 8'h18, "R3 write addr");
    send(8'h77, EN, 8'h30, "R4 data nak");
    do_stop("R7");
    s_ack_data = 1'b1;
  endtask

  task automatic t_disabled;
    logic [7:0] v;
    bit moved = 1'b0;
    wr(3'd0, STA);
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!scl_w || !sda_w) moved = 1'b1; end
    chk("R8 no bus activity", int'(moved), 0);
    rd(3'd0, v); chk("R8 no flag", v[3], 0);
    rd(3'd2, v); chk("R8 status idle", v, 8'hF8);
  endtask

  task automatic t_arb;
    logic [7:0] v;
    step(EN | STA, 8'h08, "R2 start");
    ext_pull = 1'b1;
    send(8'hA0, EN, 8'h38, "R10 arbitration lost");
    chk("R10 lines released", {scl_oe, sda_oe}, 2'b00);
    ext_pull = 1'b0;
    repeat (4) @(negedge clk);
    wr(3'd0, EN);
    rd(3'd2, v); chk("R10 back to idle", v, 8'hF8);
    rd(3'd0, v); chk("R10 flag cleared", v[3], 0);
  endtask

  task automatic measure_high(input int exp, input string req);
    int n = 0;
    @(posedge scl_w);
    while (scl_w) begin @(negedge clk); if (scl_w) n++; end
    chk(req, n, exp);
  endtask

  task automatic t_divider;
    logic [7:0] v;
    step(EN | STA, 8'h08, "R2 start");
    wr(3'd1, 8'hA0); wr(3'd0, EN);
    measure_high(10, "R11 high time default");
    wait_flag("R3");
    do_stop("R7");
    wr(3'd4, 8'd9); wr(3'd3, 8'h33);
    rd(3'd4, v); chk("R11 divider readback", v, 8'd9);
    rd(3'd3, v); chk("R1 own readback", v, 8'h33);
    step(EN | STA, 8'h08, "R2 start");
    wr(3'd1, 8'hA0); wr(3'd0, EN);
    measure_high(20, "R11 high time slow");
    wait_flag("R3");
    rd(3'd2, v); chk("R3 write addr ack slow", v, 8'h18);
    wr(3'd5, 8'h00);
    s_st = 0;
    chk("R1 srst releases scl", scl_w, 1);
    rd(3'd0, v); chk("R1 srst flag", v[3], 0);
    rd(3'd2, v); chk("R1 srst status", v, 8'hF8);
    rd(3'd4, v); chk("R1 srst divider", v, 8'd4);
    rd(3'd3, v); chk("R1 srst own", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_path();
    t_read_path();
    t_nak_paths();
    t_disabled();
    t_arb();
    t_divider();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule